// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This controller sits beside the register file of a 32-bit core and turns exception requests into register-file writes. Each cycle it looks at seven request lines (reset, undefined instruction, supervisor call, prefetch abort, data abort, normal interrupt and fast interrupt), the live status word and the address of the current instruction. It picks one unmasked request and produces the complete entry step in a single registered cycle. That step writes the new status word, saves the old one into the saved-status bank of the target mode, writes the link register of that mode and loads the vector address into the PC.

A return command takes the saved status word and the resume address from the register file. It writes both back together, so the status register and the PC never disagree for a cycle. After any action the block waits one cycle so that the register file can commit the new status before the next decision is made.

Top module: `exc_sequencer`

## Requirements
- R1: The request codes are reset=0, undefined=1, supervisor call=2, prefetch abort=3, data abort=4, interrupt=5, fast interrupt=6. The target modes and vector offsets are: reset to supervisor (5'h13) at 0x00; undefined to undefined mode (5'h1B) at 0x04; supervisor call to supervisor at 0x08; prefetch abort to abort mode (5'h17) at 0x0C; data abort to abort mode at 0x10; interrupt to interrupt mode (5'h12) at 0x18; fast interrupt to fast mode (5'h11) at 0x1C. The PC is loaded with VEC_BASE plus the offset, and VEC_BASE defaults to 0.
- R2: Among unmasked pending requests, the block serves them in this order: reset, data abort, fast interrupt, interrupt, prefetch abort, undefined, supervisor call.
- R3: The interrupt request is ignored while status bit 7 is 1, and the fast interrupt request is ignored while status bit 6 is 1.
- R4: On entry the new status word keeps bits 31:8 of the current status. Bits 4:0 take the target mode, bit 5 (16-bit instruction state) is cleared and bit 7 is set. Bit 6 is set for fast interrupt and reset entry and is kept unchanged for the others.
- R5: On entry the unmodified current status word is written to the saved-status bank of the target mode, and the link write targets that same mode. Both happen in the same cycle as the status write.
- R6: The link value is: current PC + 8 for data abort; current PC + 4 for interrupt, fast interrupt, prefetch abort and reset; and the next instruction address for undefined and supervisor call, which is PC + 2 when status bit 5 is 1 and PC + 4 otherwise.
- R7: A return command writes saved_psr to the status register and ret_pc to the PC in the same cycle, with no saved-status or link write. It is taken only when no unmasked exception request is pending; otherwise the exception wins.
- R8: Results appear on the outputs one clock after the inputs are sampled. In a cycle with no action, all four write enables and both taken flags are low.
- R9: In the cycle after any entry or return, all requests and return commands are ignored.
- R10: While rst_n is low and right after it is released, all enables and taken flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_psr | input | 32 | Live status word |
| cur_pc | input | 32 | Address of the current instruction |
| req_reset | input | 1 | Reset exception request |
| req_und | input | 1 | Undefined instruction request |
| req_svc | input | 1 | Supervisor call request |
| req_pabt | input | 1 | Prefetch abort request |
| req_dabt | input | 1 | Data abort request |
| req_irq | input | 1 | Interrupt request |
| req_fiq | input | 1 | Fast interrupt request |
| ret_cmd | input | 1 | Return-from-exception command |
| saved_psr | input | 32 | Saved status of the current mode |
| ret_pc | input | 32 | Resume address for the return |
| exc_taken | output | 1 | An entry is being written this cycle |
| ret_taken | output | 1 | A return is being written this cycle |
| exc_code | output | 3 | Code of the exception entered |
| psr_we | output | 1 | Status register write enable |
| psr_wdata | output | 32 | New status word |
| spsr_we | output | 1 | Saved-status bank write enable |
| spsr_mode | output | 5 | Mode whose saved-status bank is written |
| spsr_wdata | output | 32 | Value for the saved-status bank |
| lr_we | output | 1 | Link register write enable |
| lr_mode | output | 5 | Mode whose link register is written |
| lr_wdata | output | 32 | Link value |
| pc_we | output | 1 | PC load enable |
| pc_wdata | output | 32 | Vector or resume address |

## Verification
The assertions check on every cycle the properties that follow from the signals around them. The saved-status copy matches the status sampled one cycle earlier. The entry status has the 16-bit bit cleared, the interrupt mask set and the upper bits preserved. A return writes exactly the sampled saved status and resume address together. Every action is followed by a quiet cycle, and masked interrupts are never granted. The choice of winner among several simultaneous requests, the exact link offsets for each exception and instruction state, and the exact vector per exception are shown only by the bench's scenarios, which compare every output with a model built from the requirements.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int DATA_W  = 32;
    localparam int MODE_W  = 5;
    localparam int NUM_EXC = 7;
    localparam int CODE_W  = $clog2(NUM_EXC);

    // status word bit positions
    localparam int PSR_T = 5;
    localparam int PSR_F = 6;
    localparam int PSR_I = 7;

    typedef logic [MODE_W-1:0] mode_t;
    typedef logic [DATA_W-1:0] word_t;

    localparam mode_t MODE_FIQ = 5'h11;
    localparam mode_t MODE_IRQ = 5'h12;
    localparam mode_t MODE_SVC = 5'h13;
    localparam mode_t MODE_ABT = 5'h17;
    localparam mode_t MODE_UND = 5'h1B;

    typedef enum logic [CODE_W-1:0] {
        EXC_RESET = 3'd0,
        EXC_UND   = 3'd1,
        EXC_SVC   = 3'd2,
        EXC_PABT  = 3'd3,
        EXC_DABT  = 3'd4,
        EXC_IRQ   = 3'd5,
        EXC_FIQ   = 3'd6
    } exc_e;

    typedef struct packed {
        logic  settle;
        logic  exc_taken;
        logic  ret_taken;
        exc_e  code;
        logic  psr_we;
        word_t psr;
        logic  spsr_we;
        mode_t spsr_mode;
        word_t spsr;
        logic  lr_we;
        mode_t lr_mode;
        word_t lr;
        logic  pc_we;
        word_t pc;
    } seq_t;

    // position in the service order, 0 = served first
    function automatic int unsigned rank_of(input exc_e c);
        case (c)
            EXC_RESET: return 0;
            EXC_DABT:  return 1;
            EXC_FIQ:   return 2;
            EXC_IRQ:   return 3;
            EXC_PABT:  return 4;
            EXC_UND:   return 5;
            default:   return 6;
        endcase
    endfunction

    function automatic mode_t target_mode(input exc_e c);
        case (c)
            EXC_UND:            return MODE_UND;
            EXC_PABT, EXC_DABT: return MODE_ABT;
            EXC_IRQ:            return MODE_IRQ;
            EXC_FIQ:            return MODE_FIQ;
            default:            return MODE_SVC;
        endcase
    endfunction

    function automatic word_t vector_offset(input exc_e c);
        case (c)
            EXC_UND:  return 32'h04;
            EXC_SVC:  return 32'h08;
            EXC_PABT: return 32'h0C;
            EXC_DABT: return 32'h10;
            EXC_IRQ:  return 32'h18;
            EXC_FIQ:  return 32'h1C;
            default:  return 32'h00;
        endcase
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
#(
    parameter int N = NUM_EXC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [N-1:0]      req_vec,
    input  logic              mask_i,
    input  logic              mask_f,
    output logic              grant_vld,
    output exc_e              grant_code
);

    logic [N-1:0] live;
    int unsigned  best_rank;

    // masking: interrupt and fast interrupt gated by their status bits
    always_comb begin
        live = req_vec;
        live[EXC_IRQ] = req_vec[EXC_IRQ] & ~mask_i;
        live[EXC_FIQ] = req_vec[EXC_FIQ] & ~mask_f;
        if (!enable) live = '0;
    end

    // pick the live request with the lowest rank
    always_comb begin
        grant_vld  = 1'b0;
        grant_code = EXC_RESET;
        best_rank  = N;
        for (int k = 0; k < N; k++) begin
            if (live[k] && rank_of(exc_e'(k)) < best_rank) begin
                best_rank  = rank_of(exc_e'(k));
                grant_code = exc_e'(k);
                grant_vld  = 1'b1;
            end
        end
    end

    // R3
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vld && grant_code == EXC_IRQ) |-> !mask_i);

    // R3
    fiq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vld && grant_code == EXC_FIQ) |-> !mask_f);

    // R2
    reset_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && req_vec[EXC_RESET]) |-> (grant_vld && grant_code == EXC_RESET));

    // R9
    hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !grant_vld);

endmodule

// File: rtl/exc_entry_calc.sv
module exc_entry_calc
    import exc_pkg::*;
#(
    parameter word_t VEC_BASE = '0
) (
    input  exc_e  code,
    input  word_t cur_psr,
    input  word_t cur_pc,
    output mode_t tgt_mode,
    output word_t new_psr,
    output word_t link_val,
    output word_t vec_pc
);

    localparam word_t STEP_ARM   = 32'd4;
    localparam word_t STEP_THUMB = 32'd2;
    localparam word_t DABT_ADJ   = 32'd8;

    always_comb begin
        tgt_mode = target_mode(code);
        vec_pc   = VEC_BASE + vector_offset(code);

        new_psr               = cur_psr;
        new_psr[MODE_W-1:0]   = tgt_mode;
        new_psr[PSR_T]        = 1'b0;
        new_psr[PSR_I]        = 1'b1;
        if (code == EXC_FIQ || code == EXC_RESET)
            new_psr[PSR_F] = 1'b1;

        case (code)
            EXC_DABT:         link_val = cur_pc + DABT_ADJ;
            EXC_UND, EXC_SVC: link_val = cur_pc + (cur_psr[PSR_T] ? STEP_THUMB : STEP_ARM);
            default:          link_val = cur_pc + STEP_ARM;
        endcase
    end

endmodule

// File: rtl/exc_sequencer.sv
module exc_sequencer
    import exc_pkg::*;
#(
    parameter logic [31:0] VEC_BASE = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] cur_psr,
    input  logic [31:0] cur_pc,
    input  logic        req_reset,
    input  logic        req_und,
    input  logic        req_svc,
    input  logic        req_pabt,
    input  logic        req_dabt,
    input  logic        req_irq,
    input  logic        req_fiq,
    input  logic        ret_cmd,
    input  logic [31:0] saved_psr,
    input  logic [31:0] ret_pc,
    output logic        exc_taken,
    output logic        ret_taken,
    output logic [2:0]  exc_code,
    output logic        psr_we,
    output logic [31:0] psr_wdata,
    output logic        spsr_we,
    output logic [4:0]  spsr_mode,
    output logic [31:0] spsr_wdata,
    output logic        lr_we,
    output logic [4:0]  lr_mode,
    output logic [31:0] lr_wdata,
    output logic        pc_we,
    output logic [31:0] pc_wdata
);

    seq_t seq_d, seq_q;

    logic [NUM_EXC-1:0] req_vec;
    logic               decide_en;
    logic               grant_vld;
    exc_e               grant_code;
    mode_t              tgt_mode;
    word_t              new_psr, link_val, vec_pc;

    always_comb begin
        req_vec            = '0;
        req_vec[EXC_RESET] = req_reset;
        req_vec[EXC_UND]   = req_und;
        req_vec[EXC_SVC]   = req_svc;
        req_vec[EXC_PABT]  = req_pabt;
        req_vec[EXC_DABT]  = req_dabt;
        req_vec[EXC_IRQ]   = req_irq;
        req_vec[EXC_FIQ]   = req_fiq;
    end

    assign decide_en = ~seq_q.settle;

    exc_arbiter #(.N(NUM_EXC)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (decide_en),
        .req_vec    (req_vec),
        .mask_i     (cur_psr[PSR_I]),
        .mask_f     (cur_psr[PSR_F]),
        .grant_vld  (grant_vld),
        .grant_code (grant_code)
    );

    exc_entry_calc #(.VEC_BASE(VEC_BASE)) u_calc (
        .code     (grant_code),
        .cur_psr  (cur_psr),
        .cur_pc   (cur_pc),
        .tgt_mode (tgt_mode),
        .new_psr  (new_psr),
        .link_val (link_val),
        .vec_pc   (vec_pc)
    );

    always_comb begin
        seq_d = '0;
        if (grant_vld) begin
            seq_d.settle    = 1'b1;
            seq_d.exc_taken = 1'b1;
            seq_d.code      = grant_code;
            seq_d.psr_we    = 1'b1;
            seq_d.psr       = new_psr;
            seq_d.spsr_we   = 1'b1;
            seq_d.spsr_mode = tgt_mode;
            seq_d.spsr      = cur_psr;
            seq_d.lr_we     = 1'b1;
            seq_d.lr_mode   = tgt_mode;
            seq_d.lr        = link_val;
            seq_d.pc_we     = 1'b1;
            seq_d.pc        = vec_pc;
        end else if (decide_en && ret_cmd) begin
            seq_d.settle    = 1'b1;
            seq_d.ret_taken = 1'b1;
            seq_d.psr_we    = 1'b1;
            seq_d.psr       = saved_psr;
            seq_d.pc_we     = 1'b1;
            seq_d.pc        = ret_pc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign exc_taken  = seq_q.exc_taken;
    assign ret_taken  = seq_q.ret_taken;
    assign exc_code   = seq_q.code;
    assign psr_we     = seq_q.psr_we;
    assign psr_wdata  = seq_q.psr;
    assign spsr_we    = seq_q.spsr_we;
    assign spsr_mode  = seq_q.spsr_mode;
    assign spsr_wdata = seq_q.spsr;
    assign lr_we      = seq_q.lr_we;
    assign lr_mode    = seq_q.lr_mode;
    assign lr_wdata   = seq_q.lr;
    assign pc_we      = seq_q.pc_we;
    assign pc_wdata   = seq_q.pc;

    // R5
    spsr_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |-> (spsr_we && spsr_wdata == $past(cur_psr)
                       && spsr_mode == psr_wdata[4:0] && lr_mode == psr_wdata[4:0]));

    // R4
    entry_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |-> (!psr_wdata[PSR_T] && psr_wdata[PSR_I]
                       && psr_wdata[31:8] == $past(cur_psr[31:8])));

    // R7
    ret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_taken |-> (psr_we && pc_we && !spsr_we && !lr_we
                       && psr_wdata == $past(saved_psr) && pc_wdata == $past(ret_pc)));

    // R9
    quiet_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_taken || ret_taken) |=> (!exc_taken && !ret_taken));

    // R8
    idle_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_taken && !ret_taken) |-> (!psr_we && !spsr_we && !lr_we && !pc_we));

    // R1
    vector_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |-> (pc_we && pc_wdata[1:0] == 2'b00 && pc_wdata - VEC_BASE <= 32'h1C));

endmodule

// File: tb/sim_exc_sequencer.sv
module sim_exc_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int N_RAND     = 400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cur_psr = '0, cur_pc = '0, saved_psr = '0, ret_pc = '0;
    logic [6:0]  rq = '0;
    logic        ret_cmd = 1'b0;

    logic        exc_taken, ret_taken, psr_we, spsr_we, lr_we, pc_we;
    logic [2:0]  exc_code;
    logic [4:0]  spsr_mode, lr_mode;
    logic [31:0] psr_wdata, spsr_wdata, lr_wdata, pc_wdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .cur_psr(cur_psr), .cur_pc(cur_pc),
        .req_reset(rq[0]), .req_und(rq[1]), .req_svc(rq[2]), .req_pabt(rq[3]),
        .req_dabt(rq[4]), .req_irq(rq[5]), .req_fiq(rq[6]),
        .ret_cmd(ret_cmd), .saved_psr(saved_psr), .ret_pc(ret_pc),
        .exc_taken(exc_taken), .ret_taken(ret_taken), .exc_code(exc_code),
        .psr_we(psr_we), .psr_wdata(psr_wdata), .spsr_we(spsr_we),
        .spsr_mode(spsr_mode), .spsr_wdata(spsr_wdata), .lr_we(lr_we),
        .lr_mode(lr_mode), .lr_wdata(lr_wdata), .pc_we(pc_we), .pc_wdata(pc_wdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected mode and offset per code (R1)
    function automatic logic [4:0] m_mode(input int c);
        case (c)
            1: return 5'h1B;
            3, 4: return 5'h17;
            5: return 5'h12;
            6: return 5'h11;
            default: return 5'h13;
        endcase
    endfunction

    function automatic logic [31:0] m_off(input int c);
        case (c)
            1: return 32'h04; 2: return 32'h08; 3: return 32'h0C;
            4: return 32'h10; 5: return 32'h18; 6: return 32'h1C;
            default: return 32'h00;
        endcase
    endfunction

    // winner per R2/R3, -1 if none
    function automatic int m_pick(input logic [6:0] r, input logic [31:0] psr);
        int order[7] = '{0, 4, 6, 5, 3, 1, 2};
        logic [6:0] lv = r;
        if (psr[7]) lv[5] = 1'b0;
        if (psr[6]) lv[6] = 1'b0;
        foreach (order[k]) if (lv[order[k]]) return order[k];
        return -1;
    endfunction

    function automatic logic [31:0] m_link(input int c, input logic [31:0] psr, input logic [31:0] pc);
        if (c == 4) return pc + 32'd8;
        if (c == 1 || c == 2) return pc + (psr[5] ? 32'd2 : 32'd4);
        return pc + 32'd4;
    endfunction

    function automatic logic [31:0] m_psr(input int c, input logic [31:0] psr);
        logic [31:0] p = psr;
        p[4:0] = m_mode(c);
        p[5] = 1'b0;
        p[7] = 1'b1;
        if (c == 6 || c == 0) p[6] = 1'b1;
        return p;
    endfunction

    // compare outputs with the model for the inputs sampled one edge before
    task automatic compare(input logic [6:0] r, input logic [31:0] psr, input logic [31:0] pc,
                           input logic rc, input logic [31:0] sp, input logic [31:0] rp);
        int w = m_pick(r, psr);
        if (w >= 0) begin
            chk(exc_taken && !ret_taken, "R2 taken", {30'd0, exc_taken, ret_taken}, 32'd2);
            chk(exc_code == w[2:0], "R2 code", {29'd0, exc_code}, w);
            chk(pc_we && pc_wdata == m_off(w), "R1 vector", pc_wdata, m_off(w));
            chk(spsr_mode == m_mode(w) && lr_mode == m_mode(w), "R1 mode", {27'd0, spsr_mode}, {27'd0, m_mode(w)});
            chk(psr_we && psr_wdata == m_psr(w, psr), "R4 new status", psr_wdata, m_psr(w, psr));
            chk(spsr_we && spsr_wdata == psr, "R5 saved status", spsr_wdata, psr);
            chk(lr_we && lr_wdata == m_link(w, psr, pc), "R6 link", lr_wdata, m_link(w, psr, pc));
        end else if (rc) begin
            chk(ret_taken && !exc_taken, "R7 ret taken", {30'd0, exc_taken, ret_taken}, 32'd1);
            chk(psr_we && psr_wdata == sp, "R7 status", psr_wdata, sp);
            chk(pc_we && pc_wdata == rp, "R7 pc", pc_wdata, rp);
            chk(!spsr_we && !lr_we, "R7 no bank write", {30'd0, spsr_we, lr_we}, 32'd0);
        end else begin
            chk(!exc_taken && !ret_taken && !psr_we && !spsr_we && !lr_we && !pc_we,
                "R8 idle", {26'd0, exc_taken, ret_taken, psr_we, spsr_we, lr_we, pc_we}, 32'd0);
        end
    endtask

    task automatic idle_enables(input string req);
        chk(!exc_taken && !ret_taken && !psr_we && !spsr_we && !lr_we && !pc_we,
            req, {26'd0, exc_taken, ret_taken, psr_we, spsr_we, lr_we, pc_we}, 32'd0);
    endtask

    task automatic run_case(input logic [6:0] r, input logic [31:0] psr, input logic [31:0] pc,
                            input logic rc, input logic [31:0] sp, input logic [31:0] rp);
        rq = r; cur_psr = psr; cur_pc = pc; ret_cmd = rc; saved_psr = sp; ret_pc = rp;
        @(posedge clk); @(negedge clk);
        compare(r, psr, pc, rc, sp, rp);
        rq = '0; ret_cmd = 1'b0;
        @(posedge clk); @(negedge clk);
        idle_enables("R8 quiet after case");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        rq = 7'h7F; ret_cmd = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        idle_enables("R10 in reset");
        rq = '0; ret_cmd = 1'b0;
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        idle_enables("R10 after release");

        // R2: reset beats everything
        run_case(7'h7F, 32'h0000_0010, 32'h100, 1'b1, 32'h1, 32'h2);
        // R2: data abort over unmasked interrupt
        run_case(7'b0110000, 32'h0000_0010, 32'h200, 1'b0, 0, 0);
        // R3: both interrupts masked, supervisor call wins
        run_case(7'b1100100, 32'h0000_00D0, 32'h300, 1'b0, 0, 0);
        // R3: fast masked only, interrupt wins
        run_case(7'b1100000, 32'h0000_0050, 32'h400, 1'b0, 0, 0);
        // R6: undefined in 16-bit state links to PC + 2
        run_case(7'b0000010, 32'hF000_0030, 32'h502, 1'b0, 0, 0);
        // R6: supervisor call in 32-bit state links to PC + 4
        run_case(7'b0000100, 32'h0000_0010, 32'h600, 1'b0, 0, 0);
        // R7: return while only a masked interrupt is pending
        run_case(7'b0100000, 32'h0000_0092, 32'h700, 1'b1, 32'h6000_0010, 32'h1234);
        // R7: unmasked interrupt beats return
        run_case(7'b0100000, 32'h0000_0013, 32'h800, 1'b1, 32'h10, 32'h5678);
        // R4: fast interrupt keeps upper status bits, sets bit 6
        run_case(7'b1000000, 32'hA5A5_0030, 32'h900, 1'b0, 0, 0);

        // R9: request held through the quiet cycle
        rq = 7'b0001000; cur_psr = 32'h10; cur_pc = 32'hA00;
        @(posedge clk); @(negedge clk);
        chk(exc_taken && exc_code == 3'd3, "R9 first take", {29'd0, exc_code}, 32'd3);
        @(posedge clk); @(negedge clk);
        idle_enables("R9 held request ignored");
        @(posedge clk); @(negedge clk);
        chk(exc_taken && exc_code == 3'd3, "R9 taken again", {29'd0, exc_code}, 32'd3);
        rq = '0;
        @(posedge clk); @(negedge clk);
        // R9: return held through quiet cycle
        ret_cmd = 1'b1; saved_psr = 32'h1F; ret_pc = 32'hBEE0;
        @(posedge clk); @(negedge clk);
        chk(ret_taken, "R9 return take", {31'd0, ret_taken}, 32'd1);
        @(posedge clk); @(negedge clk);
        idle_enables("R9 held return ignored");
        ret_cmd = 1'b0;
        @(posedge clk); @(negedge clk);

        for (int i = 0; i < N_RAND; i++) begin
            logic [6:0]  r;
            logic [31:0] p, pc;
            logic [4:0]  modes [6] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B};
            r = 7'($urandom & $urandom);
            if ($urandom_range(0, 3) == 0) r = '0;
            p = $urandom;
            p[4:0] = modes[$urandom_range(0, 5)];
            pc = $urandom;
            pc[0] = 1'b0;
            if (!p[5]) pc[1] = 1'b0;
            run_case(r, p, pc, 1'($urandom), $urandom, $urandom);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule